// File: doc/BRIEF.md
# Prescaled I2C Serial Clock Generator

This block produces the SCL timing for an I2C master from the peripheral clock. It has two stages. A 5-bit prescaler makes a reference tick. A 3-bit selector then counts that tick into the low and high halves of each SCL period. The same tick sets the sampling interval of a glitch filter on the incoming SDA and SCL lines, so the prescaler width is also the noise-rejection width.

A byte-level controller sits beside this block and relies on two strobes: one when SCL is pulled low, which is the safe moment to change SDA, and one in the middle of the high half, which is the moment to sample SDA. The controller also raises a busy flag between START and STOP. New divider settings are accepted only while that flag is low. SCL is an open-drain output: the block either pulls the line low or releases it. The block also reads the line back, so a slave that stretches SCL delays the high half.

Top module: `scl_clkgen`

## Requirements
- R1: The prescale code `prs_code_i` selects a ratio p: codes 1 to 31 divide the clock by their own value, and code 0 divides by 32.
- R2: After reset the active prescale ratio is 1 and the active select value is 0, whatever the inputs are, until the bus is seen idle. SCL is released, both filtered outputs are 1 and both strobes are 0.
- R3: With select value n, the line is pulled low for p·(2^(n+1)+8) clock cycles and then released for the same number of cycles. The full period is p·(2^(n+2)+16) cycles.
- R4: Configuration inputs are copied into the active settings only on cycles when `bus_busy_i` is 0. Changes made while it is 1 leave the running period unchanged.
- R5: On both SDA and SCL, a pulse shorter than one prescaler tick never reaches the filtered output. A level held for at least two ticks does reach it.
- R6: A filtered output changes only on a clock edge where a prescaler tick occurs, and only to the value its input had on that edge.
- R7: While SCL is released but read back low, the count of the high half is paused. With p = 1, each cycle of stretching adds one cycle to the period.
- R8: `fall_stb_o` is high for one cycle, in the first cycle of each low half. `mid_stb_o` is high for one cycle, p·(2^n+4) cycles after SCL is released, provided the line is not stretched. The two strobes never overlap.
- R9: When `enable_i` is 0, SCL is released and no strobes are produced from the next cycle on. When `enable_i` goes to 1, the fall strobe appears in the next cycle and is followed by a full-length low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| prs_code_i | input | 5 | Prescale code (0 means divide by 32) |
| sck_sel_i | input | 3 | Serial clock select n |
| bus_busy_i | input | 1 | High between START and STOP; blocks configuration updates |
| enable_i | input | 1 | Runs the SCL phase engine |
| scl_i | input | 1 | SCL line as read back, already synchronous |
| sda_i | input | 1 | SDA line as read back, already synchronous |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| scl_filt_o | output | 1 | Glitch-filtered SCL |
| sda_filt_o | output | 1 | Glitch-filtered SDA |
| fall_stb_o | output | 1 | One-cycle strobe at the start of the low half |
| mid_stb_o | output | 1 | One-cycle strobe in the middle of the high half |

## Verification
The assertions take `scl_i` and `sda_i` to be synchronous to the clock already, and they take the reset to be active from time zero. They also assume the configuration changes only on clock edges. The bench drives every input at the falling edge and builds the SCL line as a wired-AND of the block's own pull-down and a bench pull-down. This keeps read-back behaving like a real open-drain line, with no combinational path from the input back into the block. Stretching and glitches are applied only through that pull-down and through the SDA drive. Configurations are loaded during idle windows, except in the one test that deliberately changes them while the bus is busy.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;

  // Phase of the serial clock engine
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;

  // Default field widths
  localparam int unsigned PRS_W_DEF = 5;
  localparam int unsigned SCK_W_DEF = 3;

endpackage

// File: rtl/scl_clkgen_prescaler.sv
module scl_clkgen_prescaler #(
  parameter int unsigned PRS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRS_W-1:0] code_i,
  input  logic             restart_i,
  output logic             tick_o
);

  // Code c divides by c; code 0 wraps to all ones, giving 2**PRS_W.
  logic [PRS_W-1:0] term;
  logic [PRS_W-1:0] cnt_q, cnt_d;
  logic             tick;

  assign term   = code_i - PRS_W'(1);
  assign tick   = (cnt_q >= term);
  assign tick_o = tick;

  always_comb begin
    cnt_d = cnt_q + PRS_W'(1);
    if (restart_i || tick) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // With a unit ratio, every cycle is a tick
  assert_unit_ratio_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == PRS_W'(1)) |-> tick_o);

  // After a restart the next tick is never earlier than the full ratio
  assert_restart_clears_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && code_i != PRS_W'(1) && $stable(code_i)) |=> !tick_o || (code_i == PRS_W'(1)));

endmodule

// File: rtl/scl_clkgen_filter.sv
module scl_clkgen_filter #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic din_i,
  output logic dout_o
);

  logic smp_q, smp_d;
  logic out_q, out_d;

  // Sample on every tick; pass a level only when two tick samples agree
  always_comb begin
    smp_d = smp_q;
    out_d = out_q;
    if (tick_i) begin
      smp_d = din_i;
      if (din_i == smp_q) begin
        out_d = din_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q <= RST_VAL;
      out_q <= RST_VAL;
    end else begin
      smp_q <= smp_d;
      out_q <= out_d;
    end
  end

  assign dout_o = out_q;

  assert_change_on_tick_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_o) |-> ($past(tick_i) && ($past(din_i) == dout_o)));

  assert_two_samples_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_o) |-> ($past(smp_q) == dout_o));

endmodule

// File: rtl/scl_clkgen_engine.sv
module scl_clkgen_engine
  import scl_clkgen_pkg::*;
#(
  parameter int unsigned SCK_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             tick_i,
  input  logic [SCK_W-1:0] sck_i,
  input  logic             scl_i,
  output logic             restart_o,
  output logic             scl_oe_o,
  output logic             fall_stb_o,
  output logic             mid_stb_o
);

  localparam int unsigned CNT_W = (1 << SCK_W) + 1;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  scl_phase_e       ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] half_m1, mid_m1;
  logic             en_q;
  logic             oe_q, oe_d;
  logic             fall_q, fall_d;
  logic             mid_q, mid_d;

  // Half phase = 2**(n+1) + 8 ticks; middle of it = 2**n + 4 ticks
  assign half_m1   = ((ONE << sck_i) << 1) + CNT_W'(7);
  assign mid_m1    = (ONE << sck_i) + CNT_W'(3);
  assign restart_o = enable_i && !en_q;

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    fall_d = 1'b0;
    mid_d  = 1'b0;
    if (!enable_i) begin
      ph_d  = PH_OFF;
      cnt_d = '0;
    end else begin
      unique case (ph_q)
        PH_OFF: begin
          ph_d   = PH_LOW;
          cnt_d  = '0;
          fall_d = 1'b1;
        end
        PH_LOW: begin
          if (tick_i) begin
            if (cnt_q >= half_m1) begin
              ph_d  = PH_HIGH;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end
        end
        PH_HIGH: begin
          if (tick_i && scl_i) begin
            if (cnt_q == mid_m1) begin
              mid_d = 1'b1;
            end
            if (cnt_q >= half_m1) begin
              ph_d   = PH_LOW;
              cnt_d  = '0;
              fall_d = 1'b1;
              mid_d  = 1'b0;
            end else begin
              cnt_d = cnt_q + ONE;
            end
          end
        end
        default: begin
          ph_d  = PH_OFF;
          cnt_d = '0;
        end
      endcase
    end
    oe_d = (ph_d == PH_LOW);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_OFF;
      cnt_q  <= '0;
      en_q   <= 1'b0;
      oe_q   <= 1'b0;
      fall_q <= 1'b0;
      mid_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      en_q   <= enable_i;
      oe_q   <= oe_d;
      fall_q <= fall_d;
      mid_q  <= mid_d;
    end
  end

  assign scl_oe_o   = oe_q;
  assign fall_stb_o = fall_q;
  assign mid_stb_o  = mid_q;

  assert_fall_drives_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_stb_o |-> scl_oe_o);

  assert_drive_has_fall_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(scl_oe_o) |-> fall_stb_o);

  assert_mid_released_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    mid_stb_o |-> !scl_oe_o);

  assert_strobes_apart_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fall_stb_o, mid_stb_o}));

  assert_off_released_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!scl_oe_o && !fall_stb_o && !mid_stb_o));

  assert_enable_starts_low_R9 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> (scl_oe_o && fall_stb_o));

  assert_stretch_pause_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_HIGH && enable_i && !scl_i) |=> ($stable(cnt_q) && !scl_oe_o));

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
  import scl_clkgen_pkg::*;
#(
  parameter int unsigned PRS_W = PRS_W_DEF,
  parameter int unsigned SCK_W = SCK_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PRS_W-1:0] prs_code_i,
  input  logic [SCK_W-1:0] sck_sel_i,
  input  logic             bus_busy_i,
  input  logic             enable_i,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             scl_filt_o,
  output logic             sda_filt_o,
  output logic             fall_stb_o,
  output logic             mid_stb_o
);

  localparam int unsigned      NLINES  = 2;
  localparam logic [PRS_W-1:0] PRS_RST = PRS_W'(1);
  localparam logic [SCK_W-1:0] SCK_RST = '0;

  logic [PRS_W-1:0]  prs_q, prs_d;
  logic [SCK_W-1:0]  sck_q, sck_d;
  logic              tick;
  logic              restart;
  logic [NLINES-1:0] raw_lines;
  logic [NLINES-1:0] flt_lines;

  // Active settings follow the inputs only while the bus is idle
  always_comb begin
    prs_d = prs_q;
    sck_d = sck_q;
    if (!bus_busy_i) begin
      prs_d = prs_code_i;
      sck_d = sck_sel_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prs_q <= PRS_RST;
      sck_q <= SCK_RST;
    end else begin
      prs_q <= prs_d;
      sck_q <= sck_d;
    end
  end

  assert_cfg_frozen_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_busy_i) |-> ($stable(prs_q) && $stable(sck_q)));

  scl_clkgen_prescaler #(
    .PRS_W(PRS_W)
  ) u_prescaler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .code_i   (prs_q),
    .restart_i(restart),
    .tick_o   (tick)
  );

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filter
    scl_clkgen_filter #(
      .RST_VAL(1'b1)
    ) u_filter (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .tick_i(tick),
      .din_i (raw_lines[g]),
      .dout_o(flt_lines[g])
    );
  end

  assign sda_filt_o = flt_lines[0];
  assign scl_filt_o = flt_lines[1];

  scl_clkgen_engine #(
    .SCK_W(SCK_W)
  ) u_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .tick_i    (tick),
    .sck_i     (sck_q),
    .scl_i     (scl_i),
    .restart_o (restart),
    .scl_oe_o  (scl_oe_o),
    .fall_stb_o(fall_stb_o),
    .mid_stb_o (mid_stb_o)
  );

endmodule

// File: tb/scl_clkgen_bench.sv
module scl_clkgen_bench;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WD_CYCLES  = 180000;

  logic       clk;
  logic       rst_n;
  logic [4:0] prs_code;
  logic [2:0] sck_sel;
  logic       busy;
  logic       enable;
  logic       hold;
  logic       sda_drv;
  logic       scl_line;
  logic       scl_oe, scl_filt, sda_filt, fall_stb, mid_stb;

  int n_chk  = 0;
  int n_fail = 0;

  assign scl_line = !scl_oe && !hold;

  scl_clkgen u_scl_clkgen (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .prs_code_i(prs_code),
    .sck_sel_i (sck_sel),
    .bus_busy_i(busy),
    .enable_i  (enable),
    .scl_i     (scl_line),
    .sda_i     (sda_drv),
    .scl_oe_o  (scl_oe),
    .scl_filt_o(scl_filt),
    .sda_filt_o(sda_filt),
    .fall_stb_o(fall_stb),
    .mid_stb_o (mid_stb)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ratio(input int code);
    return (code == 0) ? 32 : code;
  endfunction

  function automatic int half_ticks(input int n);
    return (1 << (n + 1)) + 8;
  endfunction

  // Load a configuration while idle, then start the engine with the bus busy
  task automatic start_cfg(input int code, input int n);
    enable   = 1'b0;
    busy     = 1'b0;
    prs_code = 5'(code);
    sck_sel  = 3'(n);
    repeat (3) @(negedge clk);
    busy   = 1'b1;
    enable = 1'b1;
  endtask

  // Measure one period from a fall strobe: low length, mid offset after release, period
  task automatic measure(input int stretch, output int lo, output int md, output int per);
    int g = 0;
    int idx = 0;
    int rel = -1;
    lo = -1; md = -1; per = -1;
    while (!fall_stb && g < 40000) begin
      @(negedge clk);
      g++;
    end
    while (idx < 40000) begin
      @(negedge clk);
      idx++;
      if (rel < 0 && !scl_oe) begin
        rel = idx;
        lo  = idx;
        if (stretch > 0) hold = 1'b1;
      end
      if (rel >= 0 && stretch > 0 && idx == rel + stretch) hold = 1'b0;
      if (mid_stb && md < 0 && rel >= 0) md = idx - rel;
      if (fall_stb) begin
        per = idx;
        break;
      end
    end
    hold = 1'b0;
  endtask

  task automatic check_cfg(input int code, input int n);
    int lo, md, per, p, h;
    p = ratio(code);
    h = half_ticks(n);
    start_cfg(code, n);
    measure(0, lo, md, per);
    chk(lo == h * p, "R1/R3 low half", lo, h * p);
    chk(md == ((1 << n) + 4) * p, "R8 mid strobe offset", md, ((1 << n) + 4) * p);
    chk(per == 2 * h * p, "R3 period", per, 2 * h * p);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", WD_CYCLES, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lo, md, per;
    rst_n    = 1'b0;
    prs_code = 5'd9;
    sck_sel  = 3'd5;
    busy     = 1'b1;
    enable   = 1'b0;
    hold     = 1'b0;
    sda_drv  = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: reset state
    chk(scl_oe == 1'b0, "R2 scl released", scl_oe, 0);
    chk(sda_filt == 1'b1, "R2 sda filter", sda_filt, 1);
    chk(scl_filt == 1'b1, "R2 scl filter", scl_filt, 1);
    chk({fall_stb, mid_stb} == 2'b00, "R2 strobes", {fall_stb, mid_stb}, 0);

    // R2: defaults p=1 n=0 hold while bus stays busy
    enable = 1'b1;
    @(negedge clk);
    chk(fall_stb == 1'b1, "R9 fall on enable", fall_stb, 1);
    measure(0, lo, md, per);
    chk(per == 20, "R2 default period", per, 20);

    // R1/R3/R8 sweeps
    for (int c = 1; c <= 3; c++) begin
      for (int n = 0; n < 8; n++) check_cfg(c, n);
    end
    for (int n = 0; n < 2; n++) begin
      check_cfg(0, n);
      check_cfg(31, n);
      check_cfg(17, n);
    end

    // R4: change while busy has no effect, takes effect once idle
    start_cfg(1, 0);
    prs_code = 5'd5;
    sck_sel  = 3'd3;
    measure(0, lo, md, per);
    chk(per == 20, "R4 busy write ignored", per, 20);
    measure(0, lo, md, per);
    chk(per == 20, "R4 busy write ignored again", per, 20);
    busy = 1'b0;
    measure(0, lo, md, per);
    measure(0, lo, md, per);
    chk(per == 240, "R4 idle write applied", per, 240);
    chk(lo == 120, "R4 idle low half", lo, 120);
    chk(md == 60, "R4 idle mid offset", md, 60);

    // R7: stretching with p=1 n=0
    for (int s = 1; s <= 9; s += 4) begin
      start_cfg(1, 0);
      measure(s, lo, md, per);
      chk(per == 20 + s, "R7 stretched period", per, 20 + s);
      chk(md == 5 + s, "R7 stretched mid", md, 5 + s);
    end

    // R9: disable mid-phase releases SCL, re-enable gives full low half
    start_cfg(2, 1);
    repeat (7) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(scl_oe == 1'b0, "R9 release on disable", scl_oe, 0);
    repeat (30) begin
      @(negedge clk);
      chk(!scl_oe && !fall_stb && !mid_stb, "R9 quiet while off",
          {scl_oe, fall_stb, mid_stb}, 0);
    end
    enable = 1'b1;
    @(negedge clk);
    measure(0, lo, md, per);
    chk(lo == 24, "R9 full first low half", lo, 24);

    // R5/R6: glitch filter with p=4, engine off
    enable   = 1'b0;
    busy     = 1'b0;
    prs_code = 5'd4;
    sck_sel  = 3'd0;
    repeat (10) @(negedge clk);
    for (int off = 0; off < 4; off++) begin
      bit seen = 1'b0;
      repeat (off) @(negedge clk);
      sda_drv = 1'b0;
      hold    = 1'b1;
      repeat (3) begin
        @(negedge clk);
        if (!sda_filt || !scl_filt) seen = 1'b1;
      end
      sda_drv = 1'b1;
      hold    = 1'b0;
      repeat (12) begin
        @(negedge clk);
        if (!sda_filt || !scl_filt) seen = 1'b1;
      end
      chk(!seen, "R5 short pulse rejected", seen, 0);
    end
    for (int off = 0; off < 4; off++) begin
      bit sda_low = 1'b0;
      bit scl_low = 1'b0;
      repeat (off) @(negedge clk);
      sda_drv = 1'b0;
      hold    = 1'b1;
      repeat (14) begin
        @(negedge clk);
        if (!sda_filt) sda_low = 1'b1;
        if (!scl_filt) scl_low = 1'b1;
      end
      sda_drv = 1'b1;
      hold    = 1'b0;
      repeat (14) @(negedge clk);
      chk(sda_low, "R5 long SDA pulse passed", sda_low, 1);
      chk(scl_low, "R5 long SCL pulse passed", scl_low, 1);
      chk(sda_filt && scl_filt, "R6 filters return high", {sda_filt, scl_filt}, 3);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule